// File: doc/BRIEF.md
# Power Rise-Rate Monitor

This block watches a stream of reactor-power samples and raises a flag when power climbs too quickly. It does not measure over a timed one-minute window. Instead it keeps a reference sample in a register and measures each new, higher sample against that reference. When the rise reaches the rate threshold, the flag is set and the reference moves up to the new sample. If a sample is higher but the rise stays below the threshold, the reference stays where it is. Later small rises therefore add up against the same reference until their total crosses the threshold. A falling sample clears the flag and moves the reference down to the new value.

Samples are unsigned 12-bit values in units of 0.1% power. The default threshold is 110, which is 11.0% power. A sample counts only when its valid strobe is seen while the controller waits in Check1. A six-state controller drives a small data path:

- **Start**: the reference loads the live sample while reset is high. Once reset is low, Start moves to Check1.
- **Check1**: on a strobe, it goes to Diff if the sample is above the reference, to Adjust if it is below, and stays in Check1 if the two are equal.
- **Diff**: the difference register loads new minus reference, then the controller moves to Check2.
- **Check2**: it goes to Rate_S if the difference is at least the threshold, and otherwise back to Start.
- **Rate_S**: it sets the flag, loads the new sample into the reference, and returns to Check1.
- **Adjust**: it clears the flag, loads the new sample into the reference, and returns to Check1.

Top module: `rise_rate_monitor`

## Requirements
- R1: While `rst` is high, `max_rate` and `diff_out` are 0 and the reference loads `sample`. After release the controller passes through Start into Check1 in one cycle.
- R2: A sample is taken only when `sample_valid` is high while the controller is in Check1. A strobe in any other state is ignored, and so is a change of `sample` with no strobe.
- R3: For a taken sample above the reference, `diff_out` shows sample minus reference two cycles after the strobe edge. The value is unsigned in 0.1% units.
- R4: If that difference is at least 110, `max_rate` is 1 four cycles after the strobe edge, and the reference becomes the new sample.
- R5: If that difference is below 110, `max_rate` and the reference are unchanged. The controller returns to Check1 through Start.
- R6: For a taken sample below the reference, `max_rate` is 0 two cycles after the strobe edge. The reference becomes the new sample and `diff_out` is unchanged.
- R7: A taken sample equal to the reference leaves the controller in Check1 and changes no output.
- R8: `max_rate` is registered. It changes only in Rate_S (set) or Adjust (clear), and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; while high the reference loads `sample` |
| sample_valid | input | 1 | Strobe marking a new power sample |
| sample | input | 12 | Power sample, unsigned, 0.1% units |
| max_rate | output | 1 | Excessive rise-rate flag |
| diff_out | output | 12 | Last computed rise, new sample minus reference |

## Verification
The reference register is never visible at the ports, so a wrong reference shows up only on the next taken sample. It appears as a wrong `diff_out` two cycles later, or as a wrong flag decision four cycles later. That is why the stimulus chains samples: sub-threshold rises that must add up, exact hits at 109 and 110, drops, and equal values. If the controller is stuck outside Check1, or fails to ignore an extra strobe, the next sample or the late strobe gives a flag value different from the one expected within a handful of cycles.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
    typedef enum logic [2:0] {
        ST_START  = 3'd0,
        ST_CHECK1 = 3'd1,
        ST_DIFF   = 3'd2,
        ST_CHECK2 = 3'd3,
        ST_RATE   = 3'd4,
        ST_ADJUST = 3'd5
    } rrm_state_t;
endpackage

// File: rtl/rrm_ctrl.sv
module rrm_ctrl
    import rrm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_valid,
    input  logic       samp_gt,
    input  logic       samp_lt,
    input  logic       rise_big,
    output logic       cap_en,
    output logic       diff_en,
    output logic       ref_load,
    output logic       flag_set,
    output logic       flag_clr,
    output rrm_state_t state_o
);
    rrm_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_START;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START:  state_d = ST_CHECK1;
            ST_CHECK1: begin
                if (sample_valid && samp_gt)      state_d = ST_DIFF;
                else if (sample_valid && samp_lt) state_d = ST_ADJUST;
            end
            ST_DIFF:   state_d = ST_CHECK2;
            ST_CHECK2: state_d = rise_big ? ST_RATE : ST_START;
            ST_RATE:   state_d = ST_CHECK1;
            ST_ADJUST: state_d = ST_CHECK1;
            default:   state_d = ST_START;
        endcase
    end

    always_comb begin
        cap_en   = 1'b0;
        diff_en  = 1'b0;
        ref_load = 1'b0;
        flag_set = 1'b0;
        flag_clr = 1'b0;
        unique case (state_q)
            ST_START:  ;
            ST_CHECK1: cap_en = sample_valid;
            ST_DIFF:   diff_en = 1'b1;
            ST_CHECK2: ;
            ST_RATE:   begin flag_set = 1'b1; ref_load = 1'b1; end
            ST_ADJUST: begin flag_clr = 1'b1; ref_load = 1'b1; end
            default:   ;
        endcase
    end

    assign state_o = state_q;

    AST_DIFF_TO_CHECK2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIFF) |=> (state_q == ST_CHECK2)); // R3
endmodule

// File: rtl/rrm_datapath.sv
module rrm_datapath #(
    parameter int WIDTH  = 12,
    parameter int THRESH = 110
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sample,
    input  logic             cap_en,
    input  logic             diff_en,
    input  logic             ref_load,
    input  logic             flag_set,
    input  logic             flag_clr,
    output logic             samp_gt,
    output logic             samp_lt,
    output logic             rise_big,
    output logic [WIDTH-1:0] diff_q,
    output logic             flag_q
);
    localparam logic [WIDTH-1:0] THR = WIDTH'(THRESH);

    logic [WIDTH-1:0] ref_q;
    logic [WIDTH-1:0] new_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= sample;
            new_q  <= '0;
            diff_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (cap_en)   new_q  <= sample;
            if (diff_en)  diff_q <= new_q - ref_q;
            if (ref_load) ref_q  <= new_q;
            if (flag_set)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    always_comb begin
        samp_gt  = sample > ref_q;
        samp_lt  = sample < ref_q;
        rise_big = diff_q >= THR;
    end

    AST_DIFF_NONZERO: assert property (@(posedge clk) disable iff (rst)
        diff_en |=> (diff_q != '0)); // R3
endmodule

// File: rtl/rise_rate_monitor.sv
module rise_rate_monitor
    import rrm_pkg::*;
#(
    parameter int WIDTH  = 12,
    parameter int THRESH = 110
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid,
    input  logic [WIDTH-1:0] sample,
    output logic             max_rate,
    output logic [WIDTH-1:0] diff_out
);
    logic       cap_en, diff_en, ref_load, flag_set, flag_clr;
    logic       samp_gt, samp_lt, rise_big;
    rrm_state_t state;

    rrm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .samp_gt(samp_gt), .samp_lt(samp_lt), .rise_big(rise_big),
        .cap_en(cap_en), .diff_en(diff_en), .ref_load(ref_load),
        .flag_set(flag_set), .flag_clr(flag_clr), .state_o(state)
    );

    rrm_datapath #(.WIDTH(WIDTH), .THRESH(THRESH)) u_dp (
        .clk(clk), .rst(rst), .sample(sample),
        .cap_en(cap_en), .diff_en(diff_en), .ref_load(ref_load),
        .flag_set(flag_set), .flag_clr(flag_clr),
        .samp_gt(samp_gt), .samp_lt(samp_lt), .rise_big(rise_big),
        .diff_q(diff_out), .flag_q(max_rate)
    );

    AST_RATE_NEEDS_BIG: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RATE) |-> (diff_out >= WIDTH'(THRESH))); // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RATE) |=> max_rate); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADJUST) |=> !max_rate); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RATE && state != ST_ADJUST) |=> $stable(max_rate)); // R8
    AST_EQUAL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK1 && sample_valid && !samp_gt && !samp_lt)
        |=> (state == ST_CHECK1 && $stable(diff_out))); // R7
    AST_SMALL_TO_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK2 && diff_out < WIDTH'(THRESH)) |=> (state == ST_START)); // R5
endmodule

// File: tb/tb_rise_rate_monitor.sv
`timescale 1ns/1ps
module tb_rise_rate_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [11:0] sample = 12'd0;
    logic        max_rate;
    logic [11:0] diff_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic        flag;
        logic [11:0] diff;
        string       tag;
    } exp_t;
    exp_t sb[$];
    event chk_ev;

    int          m_ref;
    logic        m_flag;
    logic [11:0] m_diff;

    always #4 clk = ~clk;

    rise_rate_monitor dut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .sample(sample), .max_rate(max_rate), .diff_out(diff_out)
    );

    task automatic model(input int s);
        if (s > m_ref) begin
            m_diff = 12'(s - m_ref);
            if (s - m_ref >= 110) begin
                m_flag = 1'b1;
                m_ref  = s;
            end
        end else if (s < m_ref) begin
            m_flag = 1'b0;
            m_ref  = s;
        end
    endtask

    task automatic push_wait(input string tag);
        exp_t e;
        e.flag = m_flag;
        e.diff = m_diff;
        e.tag  = tag;
        sb.push_back(e);
        repeat (6) @(negedge clk);
        -> chk_ev;
        @(negedge clk);
    endtask

    task automatic send(input int s, input string tag);
        @(negedge clk);
        sample = 12'(s);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        model(s);
        push_wait(tag);
    endtask

    task automatic send_pair(input int a, input int b, input string tag);
        @(negedge clk);
        sample = 12'(a);
        sample_valid = 1'b1;
        @(negedge clk);
        sample = 12'(b);
        @(negedge clk);
        sample_valid = 1'b0;
        model(a);
        push_wait(tag);
    endtask

    task automatic do_reset(input int s);
        @(negedge clk);
        rst = 1'b1;
        sample = 12'(s);
        repeat (3) @(negedge clk);
        total++;
        if (max_rate !== 1'b0 || diff_out !== 12'd0) begin
            bad++;
            $display("FAIL R1 reset: flag=%0b diff=%0d expected flag=0 diff=0", max_rate, diff_out);
        end
        rst = 1'b0;
        m_ref  = s;
        m_flag = 1'b0;
        m_diff = 12'd0;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (max_rate !== e.flag || diff_out !== e.diff) begin
                    bad++;
                    $display("FAIL %s: flag=%0b diff=%0d expected flag=%0b diff=%0d",
                             e.tag, max_rate, diff_out, e.flag, e.diff);
                end
            end
        end
    end

    initial begin
        do_reset(500);
        send(560,  "R1 R3 R5 rise 60 from reset reference");
        send(610,  "R4 R5 accumulated rise reaches 110");
        send(719,  "R5 R8 rise 109 keeps flag");
        send(720,  "R4 rise exactly 110");
        send(720,  "R7 equal sample ignored");
        send(700,  "R6 drop clears flag");
        send(809,  "R5 rise 109 below threshold");
        @(negedge clk);
        sample = 12'd4095;
        repeat (3) @(negedge clk);
        sample = 12'd0;
        push_wait("R2 sample change without strobe ignored");
        send_pair(900, 100, "R2 R4 second strobe outside Check1 ignored");
        send(899,  "R6 drop by one");
        send(4095, "R3 R4 large rise to full scale");
        send(0,    "R6 drop to zero");
        send(110,  "R4 rise 110 from zero");
        do_reset(3000);
        send(3110, "R1 R4 reference reloaded by second reset");
        send(3000, "R6 drop after second reset");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule